// File: doc/BRIEF.md
# Delayed Write Completion Tracker

This block keeps the one delayed (non-posted) write that a bridge may hold at any time. A write attempt from the originating side is captured when the slot is free and the attempt carries no parity error. The captured address, command and byte enables are then offered to the destination-bus master as a pending request. When that master finishes, the block turns the request into a completion and keeps a flag for any parity error the destination target signalled.

The originating master repeats its write until a repeat matches the stored request exactly and the completion is retired. An error flag stored in the completion is passed back to that master as a parity-error report, if reporting is enabled on the originating side. The status bit for a destination-side master data parity error is set when the destination target reports the error. The originating side's detected-error pulse fires only for errors seen on the originating bus itself. A completion that no repeat ever claims is dropped when a discard timer runs out, and a sticky flag records the timeout. Memory writes, which are posted, bypass the slot and are never retried.

Top module: `dly_wr_tracker`

## Requirements
- R1: A delayed write attempt (`enq_valid`=1, `enq_posted`=0) that arrives while the slot is empty, and is not rejected under R2, is captured on that clock edge. From the next cycle `occupied`=1 and `dst_req`=1, and `dst_addr`/`dst_cmd`/`dst_be` show the captured values.
- R2: With `orig_perr_en`=1, a delayed attempt with `enq_perr`=1 is discarded: it is not captured and not retried. With `orig_perr_en`=0 the error is ignored and the attempt is captured as in R1.
- R3: `orig_dpe_set` is high in any cycle in which `enq_valid`&`enq_perr` or `rpt_valid`&`rpt_perr` holds.
- R4: While the slot is occupied, a delayed attempt that is not rejected under R2 raises `enq_retry` in the same cycle and leaves the stored request unchanged.
- R5: A posted attempt (`enq_posted`=1) never raises `enq_retry` and is never captured, whether the slot is empty or occupied.
- R6: `dst_done`=1 while `dst_req`=1 ends the request: from the next cycle `dst_req`=0 and the completion is held. If `dst_perr`=1 on that cycle, the sticky `dst_mdpe` is 1 from the next cycle on, and the error is stored in the completion.
- R7: `rpt_retire` is high in the same cycle as `rpt_valid`=1 only if a completion is held, `rpt_perr`=0, and address, command and byte enables all equal the stored ones. A retire empties the slot from the next cycle. A repeat while the request is still pending does not retire.
- R8: `rpt_perr_out` = `rpt_retire` AND stored completion error AND `orig_perr_en`, in the same cycle.
- R9: Retiring a completion, with or without a stored error, does not raise `orig_dpe_set`.
- R10: A repeat with `rpt_perr`=1 never retires, even when its fields match, and the completion stays held.
- R11: A completion that is not retired stays held for exactly DISCARD_CYCLES cycles after it is entered. The slot is then empty, and the sticky `discard_to` is 1 from then on.
- R12: After reset, `occupied`, `dst_req`, `dst_mdpe`, `discard_to`, `enq_retry`, `rpt_retire`, `rpt_perr_out` and `orig_dpe_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| orig_perr_en | input | 1 | Parity-error response enable on the originating side |
| enq_valid | input | 1 | Write attempt from the originating master |
| enq_posted | input | 1 | Attempt is a posted memory write |
| enq_addr | input | ADDR_W | Attempt address |
| enq_cmd | input | CMD_W | Attempt command |
| enq_be | input | BE_W | Attempt byte enables |
| enq_perr | input | 1 | Data parity error seen on the attempt |
| enq_retry | output | 1 | Attempt must be retried (slot busy) |
| dst_req | output | 1 | Request pending for the destination-bus master |
| dst_addr | output | ADDR_W | Stored address |
| dst_cmd | output | CMD_W | Stored command |
| dst_be | output | BE_W | Stored byte enables |
| dst_done | input | 1 | Destination master finished the write |
| dst_perr | input | 1 | Destination target reported a parity error (sampled with done) |
| rpt_valid | input | 1 | Repeat of a delayed write by the originating master |
| rpt_addr | input | ADDR_W | Repeat address |
| rpt_cmd | input | CMD_W | Repeat command |
| rpt_be | input | BE_W | Repeat byte enables |
| rpt_perr | input | 1 | Data parity error seen on the repeat |
| rpt_retire | output | 1 | Repeat retires the held completion |
| rpt_perr_out | output | 1 | Report a parity error to the originating master |
| orig_dpe_set | output | 1 | Pulse: originating-side detected parity error |
| dst_mdpe | output | 1 | Sticky destination-side master data parity error |
| discard_to | output | 1 | Sticky: a held completion was discarded |
| occupied | output | 1 | Slot holds a request or a completion |

## Verification
The assertions assume that `dst_done` arrives only while `dst_req` is high. They also assume that an originating attempt and a repeat never share a cycle, since on a real bus both come from the same master. The bench follows both rules: each task drives a single port group for one cycle and returns it to idle, and `dst_done` is raised only after `dst_req` has been seen. The retire and no-retire cases come from a table. Each entry changes one field or the error flags against the captured request, so a comparator that skips a field leaves a visible wrong retire.

// File: rtl/dwt_pkg.sv
`timescale 1ns/1ps
// Shared types for the delayed write completion tracker.
// Assumes nothing beyond IEEE 1800-2017.
package dwt_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY    = 2'd0,
        SLOT_PENDING  = 2'd1,
        SLOT_COMPLETE = 2'd2
    } slot_state_t;
endpackage

// File: rtl/dwt_req_store.sv
`timescale 1ns/1ps
// Holds the captured request fields and the completion error flag, and
// compares a repeat against them. Assumes load and set_err never coincide.
module dwt_req_store #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [BE_W-1:0]   in_be,
    input  logic              set_err,
    input  logic              err_val,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [CMD_W-1:0]  cmp_cmd,
    input  logic [BE_W-1:0]   cmp_be,
    output logic              match,
    output logic [ADDR_W-1:0] q_addr,
    output logic [CMD_W-1:0]  q_cmd,
    output logic [BE_W-1:0]   q_be,
    output logic              q_err
);
    // Capture request fields on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_cmd  <= '0;
            q_be   <= '0;
        end else if (load) begin
            q_addr <= in_addr;
            q_cmd  <= in_cmd;
            q_be   <= in_be;
        end
    end

    // Completion error flag: cleared by a new capture, written at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_err <= 1'b0;
        else if (load)    q_err <= 1'b0;
        else if (set_err) q_err <= err_val;
    end

    // All three fields must agree for a repeat to match.
    always_comb begin
        match = (cmp_addr == q_addr) && (cmp_cmd == q_cmd) && (cmp_be == q_be);
    end

    a_r1_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_addr == $past(in_addr)) && (q_cmd == $past(in_cmd)));
    a_r6_err_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (set_err && !load) |=> (q_err == $past(err_val)));
endmodule

// File: rtl/dwt_discard_timer.sv
`timescale 1ns/1ps
// Counts cycles while a completion is held and pulses expire after
// DISCARD_CYCLES of them. Assumes run drops once expire has been seen.
module dwt_discard_timer #(
    parameter int DISCARD_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(DISCARD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DISCARD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Terminal count reached while running.
    always_comb expire = run && (cnt == LAST);

    // Count up while running; restart whenever idle or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || expire)   cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/dly_wr_tracker.sv
`timescale 1ns/1ps
// Single-slot delayed write tracker. Captures one delayed write, presents
// it to the destination master, holds the completion with its parity error
// flag, and retires it on an exact repeat or drops it on timer expiry.
// Assumes an attempt and a repeat never arrive in the same cycle, and that
// dst_done is raised only while dst_req is high.
module dly_wr_tracker
    import dwt_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int CMD_W          = 4,
    parameter int BE_W           = 4,
    parameter int DISCARD_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              orig_perr_en,
    input  logic              enq_valid,
    input  logic              enq_posted,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [CMD_W-1:0]  enq_cmd,
    input  logic [BE_W-1:0]   enq_be,
    input  logic              enq_perr,
    output logic              enq_retry,
    output logic              dst_req,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CMD_W-1:0]  dst_cmd,
    output logic [BE_W-1:0]   dst_be,
    input  logic              dst_done,
    input  logic              dst_perr,
    input  logic              rpt_valid,
    input  logic [ADDR_W-1:0] rpt_addr,
    input  logic [CMD_W-1:0]  rpt_cmd,
    input  logic [BE_W-1:0]   rpt_be,
    input  logic              rpt_perr,
    output logic              rpt_retire,
    output logic              rpt_perr_out,
    output logic              orig_dpe_set,
    output logic              dst_mdpe,
    output logic              discard_to,
    output logic              occupied
);
    slot_state_t state, state_nx;
    logic dly_try, bad_try, take, finish, match, held_err, expire;

    // Classify the incoming attempt.
    always_comb begin
        dly_try = enq_valid && !enq_posted;
        bad_try = enq_perr && orig_perr_en;
        take    = dly_try && !bad_try && (state == SLOT_EMPTY);
        finish  = (state == SLOT_PENDING) && dst_done;
    end

    dwt_req_store #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BE_W(BE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .load(take), .in_addr(enq_addr), .in_cmd(enq_cmd), .in_be(enq_be),
        .set_err(finish), .err_val(dst_perr),
        .cmp_addr(rpt_addr), .cmp_cmd(rpt_cmd), .cmp_be(rpt_be),
        .match(match),
        .q_addr(dst_addr), .q_cmd(dst_cmd), .q_be(dst_be), .q_err(held_err)
    );

    dwt_discard_timer #(.DISCARD_CYCLES(DISCARD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .run(state == SLOT_COMPLETE), .expire(expire)
    );

    // Port-side responses for attempts and repeats.
    always_comb begin
        enq_retry    = dly_try && !bad_try && (state != SLOT_EMPTY);
        rpt_retire   = rpt_valid && !rpt_perr && (state == SLOT_COMPLETE) && match;
        rpt_perr_out = rpt_retire && held_err && orig_perr_en;
        orig_dpe_set = (enq_valid && enq_perr) || (rpt_valid && rpt_perr);
        dst_req      = (state == SLOT_PENDING);
        occupied     = (state != SLOT_EMPTY);
    end

    // Slot sequencing: empty -> pending -> complete -> empty.
    always_comb begin
        state_nx = state;
        case (state)
            SLOT_EMPTY:    if (take) state_nx = SLOT_PENDING;
            SLOT_PENDING:  if (dst_done) state_nx = SLOT_COMPLETE;
            SLOT_COMPLETE: if (rpt_retire || expire) state_nx = SLOT_EMPTY;
            default:       state_nx = SLOT_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nx;
    end

    // Sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_mdpe   <= 1'b0;
            discard_to <= 1'b0;
        end else begin
            if (finish && dst_perr) dst_mdpe <= 1'b1;
            if (expire && !rpt_retire) discard_to <= 1'b1;
        end
    end

    a_r1_take_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_posted && !enq_perr && !occupied) |=> dst_req);
    a_r2_bad_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_posted && enq_perr && orig_perr_en && !occupied) |=> !occupied);
    a_r4_retry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        enq_retry |=> $stable(dst_addr) && $stable(dst_be));
    a_r6_done_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req && dst_done) |=> !dst_req && occupied);
    a_r6_mdpe_set: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req && dst_done && dst_perr) |=> dst_mdpe);
    a_r6_mdpe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dst_mdpe |=> dst_mdpe);
    a_r7_retire_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_retire |=> !occupied);
    a_r9_retire_no_dpe: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_retire && !enq_valid) |-> !orig_dpe_set);
    a_r11_empty_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(occupied) |-> ($past(rpt_retire) || discard_to));
endmodule

// File: tb/dly_wr_tracker_test.sv
`timescale 1ns/1ps
module dly_wr_tracker_test;
    localparam int AW = 32, CW = 4, BW = 4, DC = 16;
    localparam logic [AW-1:0] BASE_A = 32'h1000_0040;
    localparam logic [CW-1:0] BASE_C = 4'h7;
    localparam logic [BW-1:0] BASE_B = 4'hF;

    // Vector bits: [7]dst_perr [6]orig_perr_en [5]addr diff [4]cmd diff
    //              [3]be diff [2]rpt_perr [1]exp retire [0]exp perr_out
    localparam logic [7:0] VEC [8] = '{
        8'b0_1_0_0_0_0_1_0,
        8'b1_1_0_0_0_0_1_1,
        8'b1_0_0_0_0_0_1_0,
        8'b0_1_1_0_0_0_0_0,
        8'b0_1_0_1_0_0_0_0,
        8'b0_1_0_0_1_0_0_0,
        8'b1_1_0_0_0_1_0_0,
        8'b1_1_1_1_1_0_0_0
    };

    logic clk = 0, rst_n = 0, orig_perr_en = 1;
    logic enq_valid = 0, enq_posted = 0, enq_perr = 0;
    logic [AW-1:0] enq_addr = '0;
    logic [CW-1:0] enq_cmd = '0;
    logic [BW-1:0] enq_be = '0;
    logic enq_retry, dst_req, dst_done = 0, dst_perr = 0;
    logic [AW-1:0] dst_addr;
    logic [CW-1:0] dst_cmd;
    logic [BW-1:0] dst_be;
    logic rpt_valid = 0, rpt_perr = 0;
    logic [AW-1:0] rpt_addr = '0;
    logic [CW-1:0] rpt_cmd = '0;
    logic [BW-1:0] rpt_be = '0;
    logic rpt_retire, rpt_perr_out, orig_dpe_set, dst_mdpe, discard_to, occupied;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dly_wr_tracker #(.ADDR_W(AW), .CMD_W(CW), .BE_W(BW), .DISCARD_CYCLES(DC)) uut (
        .clk(clk), .rst_n(rst_n), .orig_perr_en(orig_perr_en),
        .enq_valid(enq_valid), .enq_posted(enq_posted), .enq_addr(enq_addr),
        .enq_cmd(enq_cmd), .enq_be(enq_be), .enq_perr(enq_perr), .enq_retry(enq_retry),
        .dst_req(dst_req), .dst_addr(dst_addr), .dst_cmd(dst_cmd), .dst_be(dst_be),
        .dst_done(dst_done), .dst_perr(dst_perr),
        .rpt_valid(rpt_valid), .rpt_addr(rpt_addr), .rpt_cmd(rpt_cmd), .rpt_be(rpt_be),
        .rpt_perr(rpt_perr), .rpt_retire(rpt_retire), .rpt_perr_out(rpt_perr_out),
        .orig_dpe_set(orig_dpe_set), .dst_mdpe(dst_mdpe), .discard_to(discard_to),
        .occupied(occupied)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive one attempt for one cycle; comb outputs sampled before the edge.
    task automatic do_enq(input logic [AW-1:0] a, input logic posted, input logic perr,
                          output logic retry, output logic dpe);
        enq_valid = 1; enq_posted = posted; enq_addr = a;
        enq_cmd = BASE_C; enq_be = BASE_B; enq_perr = perr;
        #2; retry = enq_retry; dpe = orig_dpe_set;
        step();
        enq_valid = 0; enq_posted = 0; enq_perr = 0;
    endtask

    task automatic do_done(input logic perr);
        dst_done = 1; dst_perr = perr;
        step();
        dst_done = 0; dst_perr = 0;
    endtask

    task automatic do_rpt(input logic [AW-1:0] a, input logic [CW-1:0] c,
                          input logic [BW-1:0] b, input logic perr,
                          output logic ret, output logic pout, output logic dpe);
        rpt_valid = 1; rpt_addr = a; rpt_cmd = c; rpt_be = b; rpt_perr = perr;
        #2; ret = rpt_retire; pout = rpt_perr_out; dpe = orig_dpe_set;
        step();
        rpt_valid = 0; rpt_perr = 0;
    endtask

    initial begin
        logic r, d, p;
        logic mdpe_exp;
        mdpe_exp = 0;
        repeat (3) @(negedge clk);
        // R12: reset values
        check("R12 occupied", occupied, 0);
        check("R12 dst_req", dst_req, 0);
        check("R12 status", {dst_mdpe, discard_to}, 0);
        check("R12 pulses", {enq_retry, rpt_retire, rpt_perr_out, orig_dpe_set}, 0);
        rst_n = 1;
        step();

        // R5: posted write while empty is neither retried nor captured
        do_enq(32'h2000_0000, 1, 0, r, d);
        check("R5 posted no retry (empty)", r, 0);
        check("R5 posted not captured", occupied, 0);

        // R2/R3: enabled parity error discards the attempt
        orig_perr_en = 1;
        do_enq(32'h3000_0000, 0, 1, r, d);
        check("R3 dpe pulse on attempt", d, 1);
        check("R2 bad attempt not retried", r, 0);
        check("R2 bad attempt discarded", occupied, 0);

        // R1: clean capture
        do_enq(BASE_A, 0, 0, r, d);
        check("R1 occupied", occupied, 1);
        check("R1 dst_req", dst_req, 1);
        check("R1 addr", dst_addr, BASE_A);
        check("R1 cmd/be", {dst_cmd, dst_be}, {BASE_C, BASE_B});
        check("R3 no dpe on clean attempt", d, 0);

        // R7: matching repeat while pending does not retire
        do_rpt(BASE_A, BASE_C, BASE_B, 0, r, p, d);
        check("R7 no retire while pending", r, 0);

        // R4: retry while occupied, stored request kept
        do_enq(32'h4000_0000, 0, 0, r, d);
        check("R4 retry", r, 1);
        check("R4 entry unchanged", dst_addr, BASE_A);

        // R5: posted while occupied is not retried
        do_enq(32'h5000_0000, 1, 0, r, d);
        check("R5 posted no retry (busy)", r, 0);

        // R6: clean completion
        do_done(0);
        check("R6 dst_req drops", dst_req, 0);
        check("R6 completion held", occupied, 1);
        check("R6 no mdpe", dst_mdpe, 0);
        do_rpt(BASE_A, BASE_C, BASE_B, 0, r, p, d);
        check("R7 retire clean", r, 1);
        check("R7 empty after retire", occupied, 0);

        // R2: parity error ignored when reporting disabled
        orig_perr_en = 0;
        do_enq(BASE_A, 0, 1, r, d);
        check("R2 captured when disabled", occupied, 1);
        do_done(0);
        do_rpt(BASE_A, BASE_C, BASE_B, 0, r, p, d);
        check("R7 retire after disabled capture", r, 1);

        // Table of completion/repeat combinations (R6..R10)
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            logic [AW-1:0] ra;
            logic [CW-1:0] rc;
            logic [BW-1:0] rb;
            v = VEC[i];
            orig_perr_en = v[6];
            do_enq(BASE_A, 0, 0, r, d);
            do_done(v[7]);
            mdpe_exp = mdpe_exp | v[7];
            check($sformatf("R6 mdpe vec%0d", i), dst_mdpe, mdpe_exp);
            ra = v[5] ? (BASE_A ^ 32'h4) : BASE_A;
            rc = v[4] ? (BASE_C ^ 4'h1) : BASE_C;
            rb = v[3] ? (BASE_B ^ 4'h1) : BASE_B;
            do_rpt(ra, rc, rb, v[2], r, p, d);
            check($sformatf("R7 R10 retire vec%0d", i), r, v[1]);
            check($sformatf("R8 perr_out vec%0d", i), p, v[0]);
            check($sformatf("R3 R9 dpe vec%0d", i), d, v[2]);
            if (!v[1]) begin
                check($sformatf("R10 still held vec%0d", i), occupied, 1);
                do_rpt(BASE_A, BASE_C, BASE_B, 0, r, p, d);
            end
            check($sformatf("R7 emptied vec%0d", i), occupied, 0);
        end

        // R11: orphan completion discarded after exactly DC cycles
        orig_perr_en = 1;
        check("R11 no timeout yet", discard_to, 0);
        do_enq(BASE_A, 0, 0, r, d);
        do_done(0);
        repeat (DC - 1) step();
        check("R11 held until last cycle", occupied, 1);
        step();
        check("R11 discarded", occupied, 0);
        check("R11 timeout sticky", discard_to, 1);
        step();
        check("R11 timeout stays", discard_to, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule